// File: doc/BRIEF.md
# Dual-Mode Programmable Frequency Divider

This block divides a local-oscillator clock by a programmed integer ratio and emits one single-cycle pulse per ratio's worth of input cycles, for use as the feedback input of a phase comparator in a tuning synthesizer. Two division schemes are provided. The swallow scheme models a divide-by-16/17 dual-modulus prescaler driven by a 4-bit swallow counter and a 12-bit main counter, reaching ratios from 272 up to 65535. The direct scheme uses a 12-bit down-counter for ratios from 4 to 4095.

Two mode flags choose the scheme and the oscillator input path. A band-select flag at 1 routes the high-band input into the swallow scheme, and the second flag is then irrelevant. With band-select at 0, a fine-select flag at 1 gives the swallow scheme on the low-band input, and at 0 gives direct division on the low-band input. In the direct scheme the ratio comes from the upper 12 bits of the 16-bit ratio word, so the least significant ratio bit sits at word bit 4 instead of bit 0. A new ratio or mode is adopted only when the running period reaches its terminal count, and too-small ratios are raised to the minimum of the scheme. An inhibit control halts the divider entirely.

Top module: `lo_ratio_divider`

## Requirements
- R1: While reset is asserted, and until the first period after reset ends, `pulse_o` is 0 and `hiband_o` is 0; after reset release the first pulse appears N+3 clock cycles later (two cycles of reset synchronization plus the loading cycle).
- R2: With `band_sel_i`=1 the divider uses the swallow scheme with N equal to the full 16-bit `ratio_i` (bit 0 is the ratio LSB), pulses are exactly N cycles apart, `hiband_o` reads 1, and `fine_sel_i` has no effect.
- R3: With `band_sel_i`=0 and `fine_sel_i`=1 the divider uses the swallow scheme with N equal to the full `ratio_i`, pulses are N cycles apart and `hiband_o` reads 0.
- R4: With both flags 0 the divider counts directly with N equal to `ratio_i[15:4]`; `ratio_i[3:0]` has no effect, and `hiband_o` reads 0.
- R5: In either swallow configuration a ratio below 272 is treated as 272.
- R6: In the direct configuration a ratio field below 4 is treated as 4, so pulses are never closer than 4 cycles.
- R7: Each output pulse is high for exactly one clock cycle.
- R8: A change of ratio or flags during a period does not alter that period; the new value governs the period that starts at the next pulse.
- R9: While `inhibit_i` is 1 no pulse is produced; when it returns to 0 the divider reloads from the current inputs and the first pulse arrives N+1 cycles after the first clock edge sampling `inhibit_i` low.
- R10: `hiband_o` changes only together with a pulse, on the reload after inhibit, or on the first load after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_lo | input | 1 | Local-oscillator clock being divided |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ratio_i | input | 16 | Division ratio word from the control register |
| band_sel_i | input | 1 | 1: high-band input with swallow scheme |
| fine_sel_i | input | 1 | With band_sel_i=0: 1 swallow scheme, 0 direct 12-bit division |
| inhibit_i | input | 1 | 1 stops the divider and suppresses output pulses |
| pulse_o | output | 1 | One-cycle pulse at each terminal count |
| hiband_o | output | 1 | 1 when the period in progress uses the high-band input |

## Verification
On every cycle the assertions check that a pulse lasts a single cycle, that no pulse follows an inhibited cycle, that consecutive pulses are never closer than four cycles, and that the band indication moves only at a period boundary, a restart or just after reset. The exact period length in each of the three configurations, the ignored low nibble in direct mode, the clamping to 272 and to 4, the deferral of a mid-period ratio change and the restart latency after inhibit or reset depend on specific ratio values, so only the bench's scenarios with computed expected intervals can show them.

// File: rtl/ldiv_pkg.sv
package ldiv_pkg;
  localparam int RATIO_W    = 16;
  localparam int PS_BITS    = 4;                    // prescaler 2^PS_BITS / 2^PS_BITS+1
  localparam int CNT_W      = RATIO_W - PS_BITS;    // main and direct counter width
  localparam int PS_LEN     = 1 << PS_BITS;
  localparam int SW_MIN     = PS_LEN * (PS_LEN + 1);
  localparam int DIRECT_MIN = 4;

  typedef enum logic [1:0] {
    MODE_SWALLOW_HI = 2'd0,
    MODE_SWALLOW_LO = 2'd1,
    MODE_DIRECT     = 2'd2
  } div_mode_e;

  typedef struct packed {
    div_mode_e          mode;
    logic [CNT_W-1:0]   main;
    logic [PS_BITS-1:0] swal;
  } div_cfg_t;
endpackage

// File: rtl/ldiv_rst_sync.sv
module ldiv_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[g] <= 1'b0;
        else if (g == 0) sync_q[g] <= 1'b1;
        else sync_q[g] <= sync_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/ldiv_cfg_decode.sv
module ldiv_cfg_decode
  import ldiv_pkg::*;
(
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic               band_sel_i,
  input  logic               fine_sel_i,
  output div_cfg_t           cfg_o
);
  localparam logic [RATIO_W-1:0] SW_MIN_V  = SW_MIN[RATIO_W-1:0];
  localparam logic [CNT_W-1:0]   DIR_MIN_V = DIRECT_MIN[CNT_W-1:0];

  logic [RATIO_W-1:0] sw_ratio;
  logic [CNT_W-1:0]   dir_cnt;

  always_comb begin
    sw_ratio = (ratio_i < SW_MIN_V) ? SW_MIN_V : ratio_i;
    dir_cnt  = ratio_i[RATIO_W-1:PS_BITS];
    if (dir_cnt < DIR_MIN_V) dir_cnt = DIR_MIN_V;

    if (band_sel_i) begin
      cfg_o.mode = MODE_SWALLOW_HI;
      cfg_o.main = sw_ratio[RATIO_W-1:PS_BITS];
      cfg_o.swal = sw_ratio[PS_BITS-1:0];
    end else if (fine_sel_i) begin
      cfg_o.mode = MODE_SWALLOW_LO;
      cfg_o.main = sw_ratio[RATIO_W-1:PS_BITS];
      cfg_o.swal = sw_ratio[PS_BITS-1:0];
    end else begin
      cfg_o.mode = MODE_DIRECT;
      cfg_o.main = dir_cnt;
      cfg_o.swal = '0;
    end
  end
endmodule

// File: rtl/ldiv_engine.sv
module ldiv_engine
  import ldiv_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     inhibit_i,
  input  div_cfg_t cfg_i,
  output logic     pulse_o,
  output logic     hiband_o
);
  localparam logic [PS_BITS:0]   PRE_LONG  = PS_LEN[PS_BITS:0];        // modulus 17
  localparam logic [PS_BITS:0]   PRE_SHORT = PRE_LONG - 1'b1;          // modulus 16
  localparam logic [PS_BITS:0]   PRE_ONE   = {{PS_BITS{1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0]   CNT_ONE   = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [PS_BITS-1:0] SW_ONE    = {{(PS_BITS-1){1'b0}}, 1'b1};

  div_mode_e          mode_q, mode_d;
  logic [CNT_W-1:0]   main_q, main_d;
  logic [PS_BITS-1:0] swal_q, swal_d;
  logic [PS_BITS:0]   pre_q, pre_d;
  logic               run_q, run_d;
  logic               pulse_q, pulse_d;
  logic               cnt_en;
  logic               is_direct, pre_wrap, term;
  logic [PS_BITS:0]   pre_last;

  assign cnt_en = !inhibit_i;

  always_comb begin
    is_direct = (mode_q == MODE_DIRECT);
    pre_last  = (swal_q != '0) ? PRE_LONG : PRE_SHORT;
    pre_wrap  = !is_direct && (pre_q == pre_last);
    term      = run_q && (main_q == CNT_ONE) && (is_direct || pre_wrap);

    mode_d  = mode_q;
    main_d  = main_q;
    swal_d  = swal_q;
    pre_d   = pre_q;
    run_d   = 1'b1;
    pulse_d = 1'b0;

    if (inhibit_i) begin
      run_d = 1'b0;
    end else if (!run_q || term) begin
      mode_d  = cfg_i.mode;
      main_d  = cfg_i.main;
      swal_d  = cfg_i.swal;
      pre_d   = '0;
      pulse_d = term;
    end else if (is_direct) begin
      main_d = main_q - CNT_ONE;
    end else if (pre_wrap) begin
      pre_d  = '0;
      main_d = main_q - CNT_ONE;
      if (swal_q != '0) swal_d = swal_q - SW_ONE;
    end else begin
      pre_d = pre_q + PRE_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_SWALLOW_LO;
      main_q  <= '0;
      swal_q  <= '0;
      pre_q   <= '0;
      run_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      run_q   <= run_d;
      pulse_q <= pulse_d;
      if (cnt_en) begin
        mode_q <= mode_d;
        main_q <= main_d;
        swal_q <= swal_d;
        pre_q  <= pre_d;
      end
    end
  end

  assign pulse_o  = pulse_q;
  assign hiband_o = (mode_q == MODE_SWALLOW_HI);
endmodule

// File: rtl/lo_ratio_divider.sv
module lo_ratio_divider
  import ldiv_pkg::*;
(
  input  logic               clk_lo,
  input  logic               rst_n,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic               band_sel_i,
  input  logic               fine_sel_i,
  input  logic               inhibit_i,
  output logic               pulse_o,
  output logic               hiband_o
);
  logic     rst_n_int;
  div_cfg_t cfg_next;

  ldiv_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk_lo),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  ldiv_cfg_decode u_dec (
    .ratio_i    (ratio_i),
    .band_sel_i (band_sel_i),
    .fine_sel_i (fine_sel_i),
    .cfg_o      (cfg_next)
  );

  ldiv_engine u_eng (
    .clk       (clk_lo),
    .rst_n     (rst_n_int),
    .inhibit_i (inhibit_i),
    .cfg_i     (cfg_next),
    .pulse_o   (pulse_o),
    .hiband_o  (hiband_o)
  );
endmodule

// File: rtl/ldiv_checker.sv
module ldiv_checker
  import ldiv_pkg::*;
(
  input logic clk_lo,
  input logic rst_n,
  input logic inhibit_i,
  input logic pulse_o,
  input logic hiband_o
);
  localparam logic [RATIO_W:0] GAP_MAX = {(RATIO_W+1){1'b1}};

  logic [2:0]       age_q;
  logic [RATIO_W:0] gap_q;
  logic             seen_q;
  logic             young;

  always_ff @(posedge clk_lo or negedge rst_n) begin
    if (!rst_n) begin
      age_q  <= '0;
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      if (age_q != 3'd7) age_q <= age_q + 3'd1;
      if (pulse_o) begin
        gap_q  <= {{RATIO_W{1'b0}}, 1'b1};
        seen_q <= 1'b1;
      end else if (gap_q != GAP_MAX) begin
        gap_q <= gap_q + 1'b1;
      end
    end
  end

  assign young = (age_q < 3'd6);

  // R7
  pulse_one_cycle_chk: assert property (@(posedge clk_lo) disable iff (!rst_n)
    pulse_o |=> !pulse_o);

  // R9
  inhibit_quiet_chk: assert property (@(posedge clk_lo) disable iff (!rst_n)
    inhibit_i |=> !pulse_o);

  // R6
  min_spacing_chk: assert property (@(posedge clk_lo) disable iff (!rst_n)
    (pulse_o && seen_q) |-> (gap_q >= 4));

  // R10
  band_at_boundary_chk: assert property (@(posedge clk_lo) disable iff (!rst_n)
    (hiband_o != $past(hiband_o)) |-> (pulse_o || $past(inhibit_i) || $past(inhibit_i, 2) || young));
endmodule

bind lo_ratio_divider ldiv_checker u_chk (
  .clk_lo    (clk_lo),
  .rst_n     (rst_n),
  .inhibit_i (inhibit_i),
  .pulse_o   (pulse_o),
  .hiband_o  (hiband_o)
);

// File: tb/tb_lo_ratio_divider.sv
`timescale 1ns/1ps
module tb_lo_ratio_divider;
  localparam int LIMIT = 70000;
  localparam int WD    = 190000;
  localparam int NV    = 12;

  // fields: [38] band, [37] fine, [36:21] ratio, [20:5] period, [4] hiband, [3:0] req
  localparam logic [38:0] VEC [NV] = '{
    {1'b1, 1'b0, 16'd300,  16'd300,  1'b1, 4'd2},  // R2 plain high band
    {1'b1, 1'b1, 16'd1000, 16'd1000, 1'b1, 4'd2},  // R2 fine flag ignored
    {1'b1, 1'b0, 16'd272,  16'd272,  1'b1, 4'd2},  // R2 smallest legal ratio
    {1'b0, 1'b1, 16'd273,  16'd273,  1'b0, 4'd3},  // R3 one swallow cycle
    {1'b0, 1'b1, 16'd1023, 16'd1023, 1'b0, 4'd3},  // R3 fifteen swallow cycles
    {1'b0, 1'b0, 16'h0C8F, 16'd200,  1'b0, 4'd4},  // R4 low nibble ignored
    {1'b0, 1'b0, 16'h0050, 16'd5,    1'b0, 4'd4},  // R4 short direct
    {1'b0, 1'b0, 16'hFFF3, 16'd4095, 1'b0, 4'd4},  // R4 longest direct
    {1'b1, 1'b0, 16'd100,  16'd272,  1'b1, 4'd5},  // R5 clamp high band
    {1'b0, 1'b1, 16'd0,    16'd272,  1'b0, 4'd5},  // R5 clamp low band
    {1'b0, 1'b0, 16'h003F, 16'd4,    1'b0, 4'd6},  // R6 clamp field 3
    {1'b0, 1'b0, 16'h0000, 16'd4,    1'b0, 4'd6}   // R6 clamp field 0
  };

  logic        clk_lo;
  logic        rst_n;
  logic [15:0] ratio_i;
  logic        band_sel_i;
  logic        fine_sel_i;
  logic        inhibit_i;
  logic        pulse_o;
  logic        hiband_o;

  int  n_checks;
  int  n_fails;
  bit  done;

  lo_ratio_divider dut (
    .clk_lo     (clk_lo),
    .rst_n      (rst_n),
    .ratio_i    (ratio_i),
    .band_sel_i (band_sel_i),
    .fine_sel_i (fine_sel_i),
    .inhibit_i  (inhibit_i),
    .pulse_o    (pulse_o),
    .hiband_o   (hiband_o)
  );

  initial clk_lo = 1'b0;
  always #2 clk_lo = ~clk_lo;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_pulse(output int n);
    n = 0;
    do begin
      @(negedge clk_lo);
      n++;
    end while (!pulse_o && n < LIMIT);
  endtask

  task automatic set_cfg(input logic b, input logic f, input logic [15:0] r);
    band_sel_i = b;
    fine_sel_i = f;
    ratio_i    = r;
  endtask

  // syncs to the pulse that adopts the new setting, then measures one period
  task automatic measure(input string req, input int exp_per, input int exp_hib);
    int n;
    wait_pulse(n);
    check(hiband_o == exp_hib, req, int'(hiband_o), exp_hib);
    @(negedge clk_lo);
    check(pulse_o == 1'b0, "R7 pulse width", int'(pulse_o), 0);
    wait_pulse(n);
    check(n + 1 == exp_per, req, n + 1, exp_per);
  endtask

  initial begin
    int n;
    bit early_change;
    n_checks = 0;
    n_fails  = 0;
    done     = 1'b0;
    rst_n    = 1'b0;
    inhibit_i = 1'b0;
    set_cfg(1'b1, 1'b0, 16'd300);

    // R1 reset state
    repeat (5) @(negedge clk_lo);
    check(pulse_o == 1'b0, "R1 pulse in reset", int'(pulse_o), 0);
    check(hiband_o == 1'b0, "R1 band in reset", int'(hiband_o), 0);
    rst_n = 1'b1;
    wait_pulse(n);
    check(n == 303, "R1 first pulse after reset", n, 303);

    // table walk
    for (int i = 0; i < NV; i++) begin
      @(negedge clk_lo);
      set_cfg(VEC[i][38], VEC[i][37], VEC[i][36:21]);
      measure($sformatf("R%0d vector %0d", VEC[i][3:0], i), int'(VEC[i][20:5]), int'(VEC[i][4]));
    end

    // R8 / R10 mid-period change is deferred
    @(negedge clk_lo);
    set_cfg(1'b1, 1'b0, 16'd500);
    measure("R8 setup", 500, 1);
    repeat (100) @(negedge clk_lo);
    set_cfg(1'b0, 1'b1, 16'd300);
    early_change = 1'b0;
    n = 100;
    do begin
      if (!hiband_o) early_change = 1'b1;
      @(negedge clk_lo);
      n++;
    end while (!pulse_o && n < LIMIT);
    check(!early_change, "R10 band held mid-period", int'(early_change), 0);
    check(n == 500, "R8 running period kept", n, 500);
    check(hiband_o == 1'b0, "R10 band switched at pulse", int'(hiband_o), 0);
    @(negedge clk_lo);
    wait_pulse(n);
    check(n + 1 == 300, "R8 new period", n + 1, 300);

    // R9 inhibit
    @(negedge clk_lo);
    set_cfg(1'b1, 1'b0, 16'd300);
    measure("R9 setup", 300, 1);
    inhibit_i = 1'b1;
    n = 0;
    for (int k = 0; k < 1000; k++) begin
      @(negedge clk_lo);
      if (pulse_o) n++;
    end
    check(n == 0, "R9 no pulse while inhibited", n, 0);
    inhibit_i = 1'b0;
    wait_pulse(n);
    check(n == 301, "R9 restart latency", n, 301);

    // R1 reset in mid-run
    repeat (37) @(negedge clk_lo);
    rst_n = 1'b0;
    @(negedge clk_lo);
    check(pulse_o == 1'b0, "R1 pulse after mid-run reset", int'(pulse_o), 0);
    check(hiband_o == 1'b0, "R1 band after mid-run reset", int'(hiband_o), 0);
    @(negedge clk_lo);
    rst_n = 1'b1;
    wait_pulse(n);
    check(n == 303, "R1 restart after mid-run reset", n, 303);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (WD) @(posedge clk_lo);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", WD, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end
endmodule